// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block turns the line state of a 10/100 Ethernet transceiver into three status LED drive signals: a link LED, a speed LED and one shared LED that shows activity, collisions or duplex depending on the display mode. Its inputs are link-good, speed-is-100, duplex-is-full, a one-cycle activity pulse, a one-cycle collision pulse and a two-bit display configuration field held in a register elsewhere.

Short activity and collision events are stretched by a hold counter so a person can see them. In two of the three display modes the link LED blinks while activity is being shown, using a divided-clock square wave that always begins dark, so a single packet gives a visible flicker. All three outputs are registered, so a change of any input, including the configuration field, shows on the LEDs after the next rising clock edge.

Top module: `phy_led_driver`

## Requirements
- R1: The configuration field picks the mode: when bit 0 is 1 the plain mode is used whatever bit 1 holds; 2'b00 selects the collision mode; 2'b10 selects the duplex mode.
- R2: In every mode the speed LED is on when speed-is-100 is 1 and off when it is 0.
- R3: In plain mode the link LED follows link-good with no blinking, and the shared LED is on while the activity indication is held.
- R4: In collision mode the shared LED is on while the collision indication is held; activity pulses do not light it.
- R5: In duplex mode the shared LED is on for full duplex and off for half duplex.
- R6: In collision and duplex modes, with link good, the link LED is steadily on when no activity is held; while activity is held it blinks with a half-period of BLINK_HALF cycles, starting with a dark phase of BLINK_HALF cycles.
- R7: In every mode the link LED is off whenever link-good is 0, even while activity is held.
- R8: An activity or collision pulse keeps its indication on for exactly HOLD_CYC cycles from the next edge; a new pulse while held restarts the full hold period.
- R9: Every output reflects its inputs, including a configuration change, after the next rising clock edge.
- R10: Synchronous reset clears all three LEDs and the hold and blink counters, so no indication survives reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_good | input | 1 | Link is established |
| spd_100 | input | 1 | Link runs at 100 Mb/s |
| full_dup | input | 1 | Link is full duplex |
| act_pulse | input | 1 | One-cycle transmit/receive activity event |
| col_pulse | input | 1 | One-cycle collision event |
| led_cfg | input | 2 | Display mode field |
| led_link | output | 1 | Link LED drive, 1 = lit |
| led_speed | output | 1 | Speed LED drive, 1 = lit |
| led_share | output | 1 | Shared activity/collision/duplex LED drive, 1 = lit |

## Verification
The bench builds the driver with HOLD_CYC = 6 and BLINK_HALF = 3 instead of the human-scale defaults. With these values a whole hold window holds one dark and one lit blink phase, so the exact cycle of every blink edge, the end of a stretch and the extension by a retriggering pulse can all be checked cycle by cycle within a few dozen clocks.

// File: rtl/phyled_pkg.sv
package phyled_pkg;

    typedef enum logic [1:0] {
        DISP_PLAIN  = 2'd0,
        DISP_COLL   = 2'd1,
        DISP_DUPLEX = 2'd2
    } disp_mode_e;

    typedef struct packed {
        logic link;
        logic speed;
        logic share;
    } led_set_t;

    localparam int unsigned EVT_CHANNELS = 2;
    localparam int unsigned CH_ACT       = 0;
    localparam int unsigned CH_COL       = 1;

    function automatic disp_mode_e pick_mode(input logic [1:0] cfg);
        if (cfg[0])
            return DISP_PLAIN;
        else if (cfg[1])
            return DISP_DUPLEX;
        else
            return DISP_COLL;
    endfunction

endpackage

// File: rtl/evt_hold.sv
module evt_hold #(
    parameter int unsigned HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    output logic evt_next
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;

    always_comb begin
        if (pulse)
            cnt_n = HOLD_V;
        else if (cnt_q != '0)
            cnt_n = cnt_q - 1'b1;
        else
            cnt_n = '0;
    end

    assign evt_next = (cnt_n != '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_n;
    end

    // R8
    hold_restart_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> (cnt_q == HOLD_V));

    // R8
    hold_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= HOLD_V);

endmodule

// File: rtl/blink_phase.sv
module blink_phase #(
    parameter int unsigned BLINK_HALF = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_next,
    output logic ph_next
);
    localparam int unsigned CW = $clog2(BLINK_HALF + 1);
    localparam logic [CW-1:0] HALF_V = CW'(BLINK_HALF);

    logic [CW-1:0] cnt_q, cnt_n;
    logic          ph_q;

    always_comb begin
        if (!en_next) begin
            cnt_n   = '0;
            ph_next = 1'b0;
        end else if (cnt_q == HALF_V) begin
            cnt_n   = CW'(1);
            ph_next = ~ph_q;
        end else begin
            cnt_n   = cnt_q + 1'b1;
            ph_next = ph_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            ph_q  <= ph_next;
        end
    end

    // R6
    blink_idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> !ph_q);

    // R6
    blink_span_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= HALF_V);

endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver
    import phyled_pkg::*;
#(
    parameter int unsigned HOLD_CYC   = 2500000,
    parameter int unsigned BLINK_HALF = 3125000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_good,
    input  logic       spd_100,
    input  logic       full_dup,
    input  logic       act_pulse,
    input  logic       col_pulse,
    input  logic [1:0] led_cfg,
    output logic       led_link,
    output logic       led_speed,
    output logic       led_share
);
    disp_mode_e mode;
    logic [EVT_CHANNELS-1:0] pulse_vec;
    logic [EVT_CHANNELS-1:0] evt_vec;
    logic     blink_en;
    logic     blink_ph;
    led_set_t nxt;
    led_set_t leds_q;

    assign mode = pick_mode(led_cfg);

    assign pulse_vec[CH_ACT] = act_pulse;
    assign pulse_vec[CH_COL] = col_pulse;

    for (genvar ch = 0; ch < EVT_CHANNELS; ch++) begin : g_hold
        evt_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .pulse    (pulse_vec[ch]),
            .evt_next (evt_vec[ch])
        );
    end

    assign blink_en = link_good && evt_vec[CH_ACT] && (mode != DISP_PLAIN);

    blink_phase #(.BLINK_HALF(BLINK_HALF)) u_blink (
        .clk     (clk),
        .rst     (rst),
        .en_next (blink_en),
        .ph_next (blink_ph)
    );

    always_comb begin
        nxt.speed = spd_100;
        unique case (mode)
            DISP_PLAIN: begin
                nxt.link  = link_good;
                nxt.share = evt_vec[CH_ACT];
            end
            DISP_COLL: begin
                nxt.link  = blink_en ? blink_ph : link_good;
                nxt.share = evt_vec[CH_COL];
            end
            default: begin
                nxt.link  = blink_en ? blink_ph : link_good;
                nxt.share = full_dup;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            leds_q <= '0;
        else
            leds_q <= nxt;
    end

    assign led_link  = leds_q.link;
    assign led_speed = leds_q.speed;
    assign led_share = leds_q.share;

    // R7
    link_down_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !link_good |=> !led_link);

    // R2
    speed_on_chk: assert property (@(posedge clk) disable iff (rst)
        spd_100 |=> led_speed);

    // R2
    speed_off_chk: assert property (@(posedge clk) disable iff (rst)
        !spd_100 |=> !led_speed);

    // R5
    duplex_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (led_cfg == 2'b10) |=> (led_share == $past(full_dup)));

    // R3
    plain_link_chk: assert property (@(posedge clk) disable iff (rst)
        led_cfg[0] |=> (led_link == $past(link_good)));

    // R4
    coll_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (led_cfg == 2'b00 && col_pulse) |=> led_share);

endmodule

// File: tb/phy_led_driver_test.sv
`timescale 1ns/1ps
module phy_led_driver_test;
    localparam int unsigned HOLD = 6;
    localparam int unsigned HALF = 3;

    logic clk = 1'b0;
    logic rst;
    logic link_good, spd_100, full_dup, act_pulse, col_pulse;
    logic [1:0] led_cfg;
    logic led_link, led_speed, led_share;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    phy_led_driver #(.HOLD_CYC(HOLD), .BLINK_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .link_good(link_good), .spd_100(spd_100),
        .full_dup(full_dup), .act_pulse(act_pulse), .col_pulse(col_pulse),
        .led_cfg(led_cfg), .led_link(led_link), .led_speed(led_speed),
        .led_share(led_share)
    );

    // {cfg[1:0], link, spd, dup, exp_link, exp_speed, exp_share}
    localparam logic [7:0] VEC [8] = '{
        8'b01_110_110,
        8'b01_001_000,
        8'b11_101_100,
        8'b00_111_110,
        8'b00_010_010,
        8'b10_111_111,
        8'b10_100_100,
        8'b10_011_011
    };

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; link_good = 1'b1; spd_100 = 1'b1; full_dup = 1'b1;
        act_pulse = 1'b0; col_pulse = 1'b0; led_cfg = 2'b10;
        tick(); tick();
        // R10 reset state
        check("R10 reset link",  led_link,  1'b0);
        check("R10 reset speed", led_speed, 1'b0);
        check("R10 reset share", led_share, 1'b0);
        rst = 1'b0;

        // Static table: R1 R2 R3 R4 R5 R9
        for (int i = 0; i < 8; i++) begin
            {led_cfg, link_good, spd_100, full_dup} = VEC[i][7:3];
            tick();
            check($sformatf("R1 R3 R7 link row %0d", i),  led_link,  VEC[i][2]);
            check($sformatf("R2 speed row %0d", i),       led_speed, VEC[i][1]);
            check($sformatf("R1 R5 share row %0d", i),    led_share, VEC[i][0]);
        end

        // R3 R8: plain mode, activity stretched HOLD cycles, link steady
        led_cfg = 2'b01; link_good = 1'b1; full_dup = 1'b0;
        tick();
        act_pulse = 1'b1;
        for (int c = 0; c < HOLD + 2; c++) begin
            tick();
            act_pulse = 1'b0;
            check($sformatf("R8 plain hold c%0d", c), led_share, (c < HOLD));
            check($sformatf("R3 plain link c%0d", c), led_link, 1'b1);
        end

        // R8 retrigger after 4 cycles extends to 4+HOLD
        act_pulse = 1'b1;
        for (int c = 0; c < 4 + HOLD + 2; c++) begin
            tick();
            act_pulse = (c == 3);
            check($sformatf("R8 retrigger c%0d", c), led_share, (c < 4 + HOLD));
        end
        act_pulse = 1'b0;
        tick();

        // R6: collision mode blink starts dark for HALF, lit for HALF, then steady
        led_cfg = 2'b00;
        tick();
        act_pulse = 1'b1;
        for (int c = 0; c < HOLD + 2; c++) begin
            tick();
            act_pulse = 1'b0;
            check($sformatf("R6 blink c%0d", c), led_link, (c >= HALF));
            check($sformatf("R4 act not shown c%0d", c), led_share, 1'b0);
        end

        // R4 R8: collision held HOLD cycles
        col_pulse = 1'b1;
        for (int c = 0; c < HOLD + 1; c++) begin
            tick();
            col_pulse = 1'b0;
            check($sformatf("R4 coll hold c%0d", c), led_share, (c < HOLD));
        end

        // R6 duplex mode also blinks; share mirrors duplex
        led_cfg = 2'b10; full_dup = 1'b1;
        tick();
        act_pulse = 1'b1;
        for (int c = 0; c < HOLD + 1; c++) begin
            tick();
            act_pulse = 1'b0;
            check($sformatf("R6 dup blink c%0d", c), led_link, (c >= HALF));
            check($sformatf("R5 dup share c%0d", c), led_share, 1'b1);
        end

        // R7: link down with activity keeps link LED dark
        led_cfg = 2'b00; link_good = 1'b0;
        act_pulse = 1'b1;
        for (int c = 0; c < HOLD + 1; c++) begin
            tick();
            act_pulse = 1'b0;
            check($sformatf("R7 link down c%0d", c), led_link, 1'b0);
        end
        link_good = 1'b1;

        // R9: config change shows after one edge
        led_cfg = 2'b10; full_dup = 1'b1;
        tick();
        check("R9 duplex before change", led_share, 1'b1);
        led_cfg = 2'b01;
        tick();
        check("R9 R1 config change", led_share, 1'b0);

        // R10: held activity does not survive reset
        act_pulse = 1'b1;
        tick();
        act_pulse = 1'b0;
        check("R10 pre-reset share", led_share, 1'b1);
        do_reset();
        check("R10 during reset", led_share, 1'b0);
        tick();
        check("R10 hold cleared", led_share, 1'b0);
        check("R10 link after reset", led_link, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule